// File: doc/BRIEF.md
# Instanced Attribute Index Unit

This unit converts a linear thread index into the element index used to fetch a vertex or instance attribute. The caller picks one of four modes for each request. Pass-through returns the index unchanged and is meant for draws with no instancing. Modulo mode wraps the index by a padded vertex count. This count is an odd factor of 1, 3, 5, 7 or 9 times a power of two. Shift-divide mode divides by a power of two. Reciprocal-divide mode divides by an arbitrary constant: it multiplies by a precomputed magic multiplier, keeps the high half of the product, and applies an optional round-down correction before a final right shift.

Requests enter on a valid/ready stream and results leave on a second valid/ready stream. The unit has two register stages. The first forms the 64-bit reciprocal product. The second finishes the shift, remainder or selection. Both stages move together on one enable. When a result is held at the output and `out_ready` is low, the whole pipeline freezes and `in_ready` drops. `in_ready` is high whenever the output register is empty or is being drained in the same cycle. A request is accepted on any clock edge where `in_valid` and `in_ready` are both high. A result is consumed on any clock edge where `out_valid` and `out_ready` are both high.

Top module: `attr_index_unit`

## Requirements
- R1: Mode code 0 (pass-through) returns `in_index` unchanged on `out_index`.
- R2: Mode code 1 (modulo) returns `in_index mod ((2*k + 1) * 2^s)`, where `s` is `in_shift` and `k` is `in_xflag` in the range 0 to 4.
- R3: In modulo mode, `in_xflag` values 5, 6 and 7 select an odd factor of 1, so the modulus is `2^s`.
- R4: Mode code 2 (shift-divide) returns `in_index >> in_shift`.
- R5: Mode code 3 (reciprocal-divide) multiplies the index by `in_mult` with bit 31 forced to 1, keeps bits 63..32 of the product, and shifts that right by `in_shift`. No shift is applied before the multiply.
- R6: In mode code 3, `in_xflag == 1` selects round-down correction: the product is formed from `in_index + 1` in 33-bit arithmetic, so an index of 0xFFFFFFFF is exact. Any other `in_xflag` value selects no correction. With magic constants derived from a divisor `d`, the result equals `floor(in_index / d)`.
- R7: Every mode has the same latency. A request accepted on one clock edge shows `out_valid` high after the second edge. When `out_ready` stays high, a new request can be accepted on every edge and the results come out in the same order.
- R8: While `out_valid` is high and `out_ready` is low, `out_valid` and `out_index` hold their values and `in_ready` is low.
- R9: After reset, `out_valid` is low and `in_ready` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Unit can accept a request this cycle |
| in_index | input | 32 | Linear thread index |
| in_mode | input | 2 | 0 pass, 1 modulo, 2 shift-divide, 3 reciprocal-divide |
| in_shift | input | 5 | Power-of-two exponent or final right shift |
| in_mult | input | 32 | Magic multiplier; bit 31 is ignored and treated as 1 |
| in_xflag | input | 3 | Odd-factor selector (modulo) or round-down enable (divide) |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer accepts the result |
| out_index | output | 32 | Element index |

## Verification
The assertions assume that request fields have no unknown bits on a cycle where `in_valid` is high. They also assume that a requester facing a low `in_ready` keeps its request steady rather than withdrawing it. The bench changes inputs only on falling edges. It raises `in_valid` only while `in_ready` is known to be high, and holds each request for exactly one accepting edge. Reciprocal-divide constants are derived in the bench from the divisor with the floor-log2 and remainder rule, and bit 31 of the multiplier is cleared before it is driven. Every divide row is therefore a well-formed constant set, and the expected quotient is plain integer division.

// File: rtl/aiu_pkg.sv
package aiu_pkg;

  typedef enum logic [1:0] {
    AIU_PASS  = 2'd0,
    AIU_MOD   = 2'd1,
    AIU_SHR   = 2'd2,
    AIU_MAGIC = 2'd3
  } aiu_mode_e;

  // Largest odd-factor selector: odd factor = 2*sel + 1 = 9
  localparam int AIU_MAX_ODD_SEL = 4;

endpackage

// File: rtl/aiu_magic_mul.sv
// Reciprocal multiply: high half of (index + corr) * (mult | MSB).
module aiu_magic_mul #(
  parameter int W = 32
) (
  input  logic [W-1:0] idx,
  input  logic [W-1:0] mult,
  input  logic         round_dn,
  output logic [W-1:0] prod_hi
);
  localparam int PW = 2 * W;

  logic [W:0]    idx_ext;
  logic [W-1:0]  m_eff;
  logic [PW-1:0] a_ext;
  logic [PW-1:0] b_ext;
  logic [PW-1:0] prod;

  // widen before the increment so the all-ones index does not wrap
  assign idx_ext = {1'b0, idx} + {{W{1'b0}}, round_dn};
  assign m_eff   = mult | {1'b1, {(W-1){1'b0}}};
  assign a_ext   = {{(W-1){1'b0}}, idx_ext};
  assign b_ext   = {{W{1'b0}}, m_eff};
  assign prod    = a_ext * b_ext;
  assign prod_hi = W'(prod >> W);

endmodule

// File: rtl/aiu_odd_mod.sv
// Remainder by a small odd constant chosen by sel (1, 3, 5, ...).
module aiu_odd_mod #(
  parameter int W       = 32,
  parameter int SEL_W   = 3,
  parameter int MAX_SEL = 4
) (
  input  logic [W-1:0]     val,
  input  logic [SEL_W-1:0] sel,
  output logic [W-1:0]     rem
);
  localparam int N_ODD = MAX_SEL + 1;

  logic [W-1:0] rem_arr [N_ODD];

  for (genvar k = 0; k < N_ODD; k++) begin : g_odd
    localparam int ODD = 2 * k + 1;
    if (ODD == 1) begin : g_one
      assign rem_arr[k] = '0;
    end else begin : g_div
      assign rem_arr[k] = val % W'(ODD);
    end
  end

  // selectors beyond MAX_SEL fall back to factor 1 (remainder zero)
  always_comb begin
    rem = '0;
    for (int k = 0; k < N_ODD; k++) begin
      if (sel == SEL_W'(k)) rem = rem_arr[k];
    end
  end

endmodule

// File: rtl/attr_index_unit.sv
module attr_index_unit #(
  parameter int IDX_W   = 32,
  parameter int SHIFT_W = 5,
  parameter int XF_W    = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_valid,
  output logic               in_ready,
  input  logic [IDX_W-1:0]   in_index,
  input  logic [1:0]         in_mode,
  input  logic [SHIFT_W-1:0] in_shift,
  input  logic [IDX_W-1:0]   in_mult,
  input  logic [XF_W-1:0]    in_xflag,
  output logic               out_valid,
  input  logic               out_ready,
  output logic [IDX_W-1:0]   out_index
);
  import aiu_pkg::*;

  localparam int WIDE_W = 2 * IDX_W;
  localparam logic [IDX_W-1:0] ONES = {IDX_W{1'b1}};

  aiu_mode_e in_mode_e;
  assign in_mode_e = aiu_mode_e'(in_mode);

  // ---------------- pipeline enable ----------------
  logic adv;
  assign adv      = !out_valid || out_ready;
  assign in_ready = adv;

  // ---------------- stage 1: multiply ----------------
  logic             rnd_dn;
  logic [IDX_W-1:0] prod_hi;

  assign rnd_dn = (in_mode_e == AIU_MAGIC) && (in_xflag == XF_W'(1));

  aiu_magic_mul #(.W(IDX_W)) u_mul (
    .idx      (in_index),
    .mult     (in_mult),
    .round_dn (rnd_dn),
    .prod_hi  (prod_hi)
  );

  logic               s1_valid;
  aiu_mode_e          s1_mode;
  logic [SHIFT_W-1:0] s1_shift;
  logic [XF_W-1:0]    s1_xf;
  logic [IDX_W-1:0]   s1_idx;
  logic [IDX_W-1:0]   s1_prod;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_valid <= 1'b0;
      s1_mode  <= AIU_PASS;
      s1_shift <= '0;
      s1_xf    <= '0;
      s1_idx   <= '0;
      s1_prod  <= '0;
    end else if (adv) begin
      s1_valid <= in_valid;
      if (in_valid) begin
        s1_mode  <= in_mode_e;
        s1_shift <= in_shift;
        s1_xf    <= in_xflag;
        s1_idx   <= in_index;
        s1_prod  <= prod_hi;
      end
    end
  end

  // ---------------- stage 2: shift / remainder / select ----------------
  logic [IDX_W-1:0] quot;
  logic [IDX_W-1:0] odd_rem;
  logic [IDX_W-1:0] low_bits;
  logic [IDX_W-1:0] mod_val;
  logic [IDX_W-1:0] result;

  assign quot     = s1_idx >> s1_shift;
  assign low_bits = s1_idx & ~(ONES << s1_shift);

  aiu_odd_mod #(
    .W       (IDX_W),
    .SEL_W   (XF_W),
    .MAX_SEL (AIU_MAX_ODD_SEL)
  ) u_odd (
    .val (quot),
    .sel (s1_xf),
    .rem (odd_rem)
  );

  assign mod_val = (odd_rem << s1_shift) | low_bits;

  always_comb begin
    unique case (s1_mode)
      AIU_PASS:  result = s1_idx;
      AIU_MOD:   result = mod_val;
      AIU_SHR:   result = quot;
      AIU_MAGIC: result = s1_prod >> s1_shift;
      default:   result = s1_idx;
    endcase
  end

  aiu_mode_e          s2_mode;
  logic [SHIFT_W-1:0] s2_shift;
  logic [XF_W-1:0]    s2_xf;
  logic [IDX_W-1:0]   s2_idx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_index <= '0;
      s2_mode   <= AIU_PASS;
      s2_shift  <= '0;
      s2_xf     <= '0;
      s2_idx    <= '0;
    end else if (adv) begin
      out_valid <= s1_valid;
      if (s1_valid) begin
        out_index <= result;
        s2_mode   <= s1_mode;
        s2_shift  <= s1_shift;
        s2_xf     <= s1_xf;
        s2_idx    <= s1_idx;
      end
    end
  end

  // ---------------- assertions ----------------
  function automatic logic [WIDE_W-1:0] modulus_of(input logic [XF_W-1:0] xf,
                                                   input logic [SHIFT_W-1:0] sh);
    logic [WIDE_W-1:0] odd;
    if (xf > XF_W'(AIU_MAX_ODD_SEL)) odd = WIDE_W'(1);
    else odd = (WIDE_W'(xf) << 1) | WIDE_W'(1);
    return odd << sh;
  endfunction

  // R8
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_index)));

  // R7
  out_origin_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> $past(s1_valid));

  // R5
  magic_floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (s1_valid && s1_mode == AIU_MAGIC) |-> (s1_prod >= (s1_idx >> 1)));

  // R2
  mod_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && s2_mode == AIU_MOD) |->
      (WIDE_W'(out_index) < modulus_of(s2_xf, s2_shift)));

  // R4
  div_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && (s2_mode == AIU_SHR || s2_mode == AIU_MAGIC)) |->
      (out_index <= (s2_idx >> s2_shift)));

  // R1
  pass_equal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && s2_mode == AIU_PASS) |-> (out_index == s2_idx));

endmodule

// File: tb/attr_index_unit_tb_top.sv
module attr_index_unit_tb_top;

  localparam int CLK_PERIOD = 10;

  typedef struct packed {
    logic [1:0]  mode;
    logic [4:0]  sh;
    logic [2:0]  xf;
    logic [31:0] d;
    logic [31:0] idx;
  } vec_t;

  localparam int NV = 22;
  localparam vec_t VECS [NV] = '{
    '{2'd0, 5'd0,  3'd0, 32'd0, 32'h0000_0000},
    '{2'd0, 5'd9,  3'd3, 32'd0, 32'hFFFF_FFFF},
    '{2'd0, 5'd0,  3'd0, 32'd0, 32'h1234_5678},
    '{2'd1, 5'd4,  3'd4, 32'd0, 32'd70},
    '{2'd1, 5'd4,  3'd4, 32'd0, 32'd1000},
    '{2'd1, 5'd3,  3'd2, 32'd0, 32'hFFFF_FFFF},
    '{2'd1, 5'd0,  3'd1, 32'd0, 32'd100},
    '{2'd1, 5'd31, 3'd4, 32'd0, 32'hFFFF_FFFF},
    '{2'd1, 5'd0,  3'd0, 32'd0, 32'd5},
    '{2'd1, 5'd5,  3'd6, 32'd0, 32'd77},
    '{2'd1, 5'd2,  3'd7, 32'd0, 32'hDEAD_BEEF},
    '{2'd2, 5'd0,  3'd0, 32'd0, 32'd9},
    '{2'd2, 5'd31, 3'd0, 32'd0, 32'hFFFF_FFFF},
    '{2'd2, 5'd7,  3'd0, 32'd0, 32'hDEAD_BEEF},
    '{2'd3, 5'd0,  3'd0, 32'd3,          32'hFFFF_FFFF},
    '{2'd3, 5'd0,  3'd0, 32'd7,          32'd1000},
    '{2'd3, 5'd0,  3'd0, 32'd11,         32'hFFFF_FFFF},
    '{2'd3, 5'd0,  3'd0, 32'd5,          32'hFFFF_FFFE},
    '{2'd3, 5'd0,  3'd0, 32'd216,        32'd123456789},
    '{2'd3, 5'd0,  3'd0, 32'd1000000007, 32'hFFFF_FFFF},
    '{2'd3, 5'd0,  3'd0, 32'd6,          32'h7FFF_FFFF},
    '{2'd3, 5'd0,  3'd0, 32'hFFFF_FFFF,  32'hFFFF_FFFF}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [31:0] in_index = '0;
  logic [1:0]  in_mode = '0;
  logic [4:0]  in_shift = '0;
  logic [31:0] in_mult = '0;
  logic [2:0]  in_xflag = '0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [31:0] out_index;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  attr_index_unit dut_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_index  (in_index),
    .in_mode   (in_mode),
    .in_shift  (in_shift),
    .in_mult   (in_mult),
    .in_xflag  (in_xflag),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_index (out_index)
  );

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, got, exp);
    end
  endtask

  // reference for modes 0..2 and for raw reciprocal arithmetic
  function automatic logic [31:0] ref_simple(input logic [1:0] mode, input logic [4:0] sh,
                                             input logic [2:0] xf, input logic [31:0] idx);
    longint unsigned modulus;
    longint unsigned k;
    case (mode)
      2'd0: return idx;
      2'd1: begin
        k = (xf > 3'd4) ? 64'd0 : longint'(xf);
        modulus = (2 * k + 1) << sh;
        return 32'(longint'(idx) % modulus);
      end
      default: return idx >> sh;
    endcase
  endfunction

  function automatic logic [31:0] ref_raw_magic(input logic [31:0] mult, input logic [4:0] sh,
                                                input logic [2:0] xf, input logic [31:0] idx);
    longint unsigned a;
    longint unsigned b;
    a = longint'(idx) + ((xf == 3'd1) ? 64'd1 : 64'd0);
    b = longint'(mult) | 64'h8000_0000;
    return 32'((a * b) >> 32) >> sh;
  endfunction

  task automatic magic_consts(input logic [31:0] d, output logic [4:0] s,
                              output logic [31:0] mf, output logic [2:0] xf);
    longint unsigned p;
    longint unsigned m;
    longint unsigned e;
    s = 5'd0;
    for (int k = 0; k < 32; k++) if (d[k]) s = 5'(k);
    p = 64'd1 << (32 + int'(s));
    m = (p + longint'(d) - 1) / longint'(d);
    e = p % longint'(d);
    if (e <= (64'd1 << s)) begin
      mf = 32'(m - 1);
      xf = 3'd1;
    end else begin
      mf = 32'(m);
      xf = 3'd0;
    end
    mf[31] = 1'b0;
  endtask

  // one request with out_ready high; reports result and latency (R7)
  task automatic xfer(input logic [1:0] mode, input logic [4:0] sh, input logic [31:0] mult,
                      input logic [2:0] xf, input logic [31:0] idx,
                      output logic [31:0] got, output bit lat_ok);
    bit early;
    @(negedge clk);
    in_valid = 1'b1; in_mode = mode; in_shift = sh; in_mult = mult;
    in_xflag = xf; in_index = idx;
    @(negedge clk);
    in_valid = 1'b0;
    early = out_valid;
    @(negedge clk);
    lat_ok = !early && out_valid;
    got = out_index;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog R7 actual=hung expected=complete");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] got;
    logic [31:0] exp;
    logic [4:0]  s;
    logic [31:0] mf;
    logic [2:0]  xf;
    bit          lat_ok;

    // R9: reset state
    repeat (3) @(negedge clk);
    check("R9 out_valid in reset", {31'd0, out_valid}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R9 out_valid after reset", {31'd0, out_valid}, 32'd0);
    check("R9 in_ready after reset", {31'd0, in_ready}, 32'd1);

    // vector table: R1 R2 R3 R4 R5 R6
    for (int i = 0; i < NV; i++) begin
      if (VECS[i].mode == 2'd3) begin
        magic_consts(VECS[i].d, s, mf, xf);
        exp = VECS[i].idx / VECS[i].d;
        xfer(2'd3, s, mf, xf, VECS[i].idx, got, lat_ok);
        check($sformatf("R6 R5 divide row %0d", i), got, exp);
      end else begin
        exp = ref_simple(VECS[i].mode, VECS[i].sh, VECS[i].xf, VECS[i].idx);
        xfer(VECS[i].mode, VECS[i].sh, 32'd0, VECS[i].xf, VECS[i].idx, got, lat_ok);
        case (VECS[i].mode)
          2'd0: check($sformatf("R1 pass row %0d", i), got, exp);
          2'd1: check($sformatf("R2 R3 modulo row %0d", i), got, exp);
          default: check($sformatf("R4 shift row %0d", i), got, exp);
        endcase
      end
      check($sformatf("R7 latency row %0d", i), {31'd0, lat_ok}, 32'd1);
    end

    // R5: bit 31 of multiplier forced high
    xfer(2'd3, 5'd0, 32'h0000_0000, 3'd0, 32'h8000_0000, got, lat_ok);
    check("R5 forced top bit", got, 32'h4000_0000);
    xfer(2'd3, 5'd3, 32'h1234_5678, 3'd0, 32'hCAFE_F00D, got, lat_ok);
    check("R5 raw multiply shift", got, ref_raw_magic(32'h1234_5678, 5'd3, 3'd0, 32'hCAFE_F00D));

    // R6: xflag 2 gives no correction, xflag 1 on all-ones index
    xfer(2'd3, 5'd0, 32'h5555_5555, 3'd2, 32'hFFFF_FFFF, got, lat_ok);
    check("R6 no correction xflag 2", got, 32'hD555_5554);
    xfer(2'd3, 5'd0, 32'h5555_5555, 3'd1, 32'hFFFF_FFFF, got, lat_ok);
    check("R6 correction all-ones", got, 32'hD555_5555);

    // R7: back-to-back streaming with out_ready high
    @(negedge clk);
    in_valid = 1'b1; in_mode = 2'd0; in_index = 32'h0000_00A1;
    @(negedge clk);
    in_index = 32'h0000_00A2;
    @(negedge clk);
    check("R7 stream first", out_index, 32'h0000_00A1);
    check("R7 stream ready", {31'd0, in_ready}, 32'd1);
    in_index = 32'h0000_00A3;
    @(negedge clk);
    in_valid = 1'b0;
    check("R7 stream second", out_index, 32'h0000_00A2);
    @(negedge clk);
    check("R7 stream third", out_index, 32'h0000_00A3);
    check("R7 stream third valid", {31'd0, out_valid}, 32'd1);
    @(negedge clk);

    // R8: back-pressure holds output and blocks input
    out_ready = 1'b0;
    in_valid = 1'b1; in_mode = 2'd0; in_index = 32'hAAAA_0001;
    @(negedge clk);
    in_mode = 2'd2; in_shift = 5'd4; in_index = 32'h0000_0100;
    @(negedge clk);
    in_valid = 1'b0;
    repeat (3) @(negedge clk);
    check("R8 held valid", {31'd0, out_valid}, 32'd1);
    check("R8 held index", out_index, 32'hAAAA_0001);
    check("R8 in_ready low", {31'd0, in_ready}, 32'd0);
    out_ready = 1'b1;
    @(negedge clk);
    check("R8 second after release", out_index, 32'h0000_0010);
    check("R8 second valid", {31'd0, out_valid}, 32'd1);
    @(negedge clk);
    check("R8 drained", {31'd0, out_valid}, 32'd0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule